// File: doc/BRIEF.md
# Word-Oriented I2C Register Slave

This block is an I2C target that lets a host controller reach a bank of 16-bit command and status registers selected by an 8-bit sub-address. The bus lines are sampled by a fast system clock, and SDA is driven through an open-drain enable: when `sda_oe` is high the pad pulls SDA low. The register storage sits outside the block. The block presents an address, a write word with a one-cycle write strobe, a read word it samples, and a pop strobe for a single streaming register.

Transfers are word based. A write sends the sub-address and then a high and a low byte. A read first sets the sub-address and then reads two bytes after a repeated start. A read that starts directly with the device address (no sub-address phase) returns the register that was selected last. One designated register acts as a byte stream that can be read in a long burst. Every other register simply repeats its word when the host keeps reading.

Top module: `i2c_word_slave`

## Requirements
- R1: After reset, `sda_oe`, `reg_we` and `reg_rd_strobe` are low and `reg_addr` is 0x00.
- R2: Only the 7-bit device address 0x34 (binary 0110100) is acknowledged, with R/W in bit 0 (0 = write). After any other address the slave leaves SDA released for the rest of the transaction, acknowledges nothing and writes nothing until the next start.
- R3: A write of sub-address, high byte and low byte gets an acknowledge after every byte. It produces exactly one `reg_we` pulse, with `reg_addr` equal to the sub-address and `reg_wdata` equal to {high, low}.
- R4: Bytes that follow the low byte within the same write are acknowledged but produce no further `reg_we`.
- R5: A write that ends with a stop before its low byte has arrived writes nothing.
- R6: A word read (sub-address write, repeated start, address with R/W=1) returns `reg_rdata[15:8]` and then `reg_rdata[7:0]` of the selected register, MSB first.
- R7: A read that begins with the device address and has no sub-address phase returns the word at the most recently received sub-address.
- R8: When the host keeps acknowledging on a register other than the stream register, the third and later bytes repeat the word: high, low, high, low.
- R9: On the stream register (sub-address 0x04), after each low byte has been shifted out the slave pulses `reg_rd_strobe` for one cycle, so that successive words are delivered.
- R10: A stream burst delivers at most 56 bytes. Later bytes read as 0x00 and cause no further strobes.
- R11: After the host answers a byte with a not-acknowledge, the slave leaves SDA released until the next start. A stop also releases SDA.
- R12: The slave starts pulling SDA low only while SCL is low, and `sda_oe` does not change while SCL stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | Pull SDA low when high |
| reg_addr | output | 8 | Selected register sub-address |
| reg_wdata | output | 16 | Word to write |
| reg_we | output | 1 | One-cycle write strobe |
| reg_rdata | input | 16 | Word of the selected register |
| reg_rd_strobe | output | 1 | One-cycle pop of the stream register |

## Verification
The bus lines pass through two synchroniser flops and one edge-detect flop, and `sda_oe` is registered once more. The slave therefore pulls or releases SDA about four clocks after an SCL fall. The bench master holds each SCL half-phase for eight or sixteen clocks and reads acknowledge and data bits in the middle of the SCL-high phase, well after the drive has settled. A write strobe and a stream pop each fall in the single clock after the edge that completes the byte. The bench counts these pulses at every rising clock edge. It compares the counts and the captured address and data only after the transaction has ended. A per-clock monitor flags any rise of `sda_oe` while the master holds SCL high.

// File: rtl/i2c_wslave_pkg.sv
package i2c_wslave_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;

  typedef enum logic [3:0] {
    ST_IDLE, ST_DEV, ST_SUB, ST_WHI, ST_WLO, ST_WIGN,
    ST_ACK, ST_RD, ST_RACK, ST_WAIT
  } wst_t;
endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_i,
  input  logic sda_i,
  output logic scl_s,
  output logic sda_s,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_ev,
  output logic stop_ev
);
  logic [SYNC_STAGES-1:0] scl_q, sda_q;
  logic scl_d, sda_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_q <= '1;
      sda_q <= '1;
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_q <= {scl_q[SYNC_STAGES-2:0], scl_i};
      sda_q <= {sda_q[SYNC_STAGES-2:0], sda_i};
      scl_d <= scl_q[SYNC_STAGES-1];
      sda_d <= sda_q[SYNC_STAGES-1];
    end
  end

  assign scl_s    = scl_q[SYNC_STAGES-1];
  assign sda_s    = sda_q[SYNC_STAGES-1];
  assign scl_rise = scl_s & ~scl_d;
  assign scl_fall = ~scl_s & scl_d;
  assign start_ev = scl_s & scl_d & ~sda_s & sda_d;
  assign stop_ev  = scl_s & scl_d & sda_s & ~sda_d;
endmodule

// File: rtl/i2c_word_fsm.sv
module i2c_word_fsm
  import i2c_wslave_pkg::*;
#(
  parameter logic [6:0]        DEV_ADDR     = 7'h34,
  parameter logic [BYTE_W-1:0] STREAM_ADDR  = 8'h04,
  parameter int                STREAM_BYTES = 56
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sda_s,
  input  logic              scl_rise,
  input  logic              scl_fall,
  input  logic              start_ev,
  input  logic              stop_ev,
  input  logic [WORD_W-1:0] reg_rdata,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] reg_addr,
  output logic [WORD_W-1:0] reg_wdata,
  output logic              reg_we,
  output logic              reg_rd_strobe
);
  localparam int SB_W = $clog2(STREAM_BYTES + 1);
  localparam logic [SB_W-1:0] SB_MAX = SB_W'(STREAM_BYTES);

  wst_t              st, ack_next;
  logic [BYTE_W-1:0] sh, hi_q, tx_byte;
  logic [3:0]        bitcnt;
  logic              lo_sel, rd_acked, is_stream, stream_open;
  logic [SB_W-1:0]   sbytes;

  assign is_stream   = (reg_addr == STREAM_ADDR);
  assign stream_open = (sbytes < SB_MAX);

  always_comb begin
    if (is_stream && !stream_open) tx_byte = '0;
    else if (lo_sel)               tx_byte = reg_rdata[BYTE_W-1:0];
    else                           tx_byte = reg_rdata[WORD_W-1:BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st            <= ST_IDLE;
      ack_next      <= ST_IDLE;
      sda_oe        <= 1'b0;
      reg_addr      <= '0;
      reg_wdata     <= '0;
      reg_we        <= 1'b0;
      reg_rd_strobe <= 1'b0;
      sh            <= '0;
      hi_q          <= '0;
      bitcnt        <= '0;
      lo_sel        <= 1'b0;
      rd_acked      <= 1'b0;
      sbytes        <= '0;
    end else begin
      reg_we        <= 1'b0;
      reg_rd_strobe <= 1'b0;
      if (start_ev) begin
        st     <= ST_DEV;
        bitcnt <= '0;
        sda_oe <= 1'b0;
        sbytes <= '0;
        lo_sel <= 1'b0;
      end else if (stop_ev) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_DEV, ST_SUB, ST_WHI, ST_WLO, ST_WIGN: begin
            if (scl_rise && bitcnt < 4'd8) begin
              sh     <= {sh[BYTE_W-2:0], sda_s};
              bitcnt <= bitcnt + 4'd1;
            end else if (scl_fall && bitcnt == 4'd8) begin
              bitcnt <= '0;
              if (st == ST_DEV && sh[7:1] != DEV_ADDR) begin
                st <= ST_WAIT;
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_ACK;
                unique case (st)
                  ST_DEV: ack_next <= sh[0] ? ST_RD : ST_SUB;
                  ST_SUB: begin
                    reg_addr <= sh;
                    ack_next <= ST_WHI;
                  end
                  ST_WHI: begin
                    hi_q     <= sh;
                    ack_next <= ST_WLO;
                  end
                  ST_WLO: begin
                    reg_we    <= 1'b1;
                    reg_wdata <= {hi_q, sh};
                    ack_next  <= ST_WIGN;
                  end
                  default: ack_next <= ST_WIGN;
                endcase
              end
            end
          end
          ST_ACK: begin
            if (scl_fall) begin
              if (ack_next == ST_RD) begin
                sh     <= tx_byte;
                sda_oe <= ~tx_byte[BYTE_W-1];
                bitcnt <= 4'd1;
              end else begin
                sda_oe <= 1'b0;
                bitcnt <= '0;
              end
              st <= ack_next;
            end
          end
          ST_RD: begin
            if (scl_fall) begin
              if (bitcnt == 4'd8) begin
                sda_oe   <= 1'b0;
                bitcnt   <= '0;
                rd_acked <= 1'b0;
                st       <= ST_RACK;
              end else begin
                sda_oe <= ~sh[BYTE_W-2];
                sh     <= {sh[BYTE_W-2:0], 1'b0};
                bitcnt <= bitcnt + 4'd1;
              end
            end
          end
          ST_RACK: begin
            if (scl_rise) begin
              if (sda_s) st <= ST_WAIT;
              else       rd_acked <= 1'b1;
              if (is_stream && stream_open) begin
                sbytes <= sbytes + SB_W'(1);
                if (lo_sel) reg_rd_strobe <= 1'b1;
              end
              lo_sel <= ~lo_sel;
            end else if (scl_fall && rd_acked) begin
              sh     <= tx_byte;
              sda_oe <= ~tx_byte[BYTE_W-1];
              bitcnt <= 4'd1;
              st     <= ST_RD;
            end
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/i2c_word_slave.sv
module i2c_word_slave
  import i2c_wslave_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR     = 7'h34,
  parameter logic [7:0] STREAM_ADDR  = 8'h04,
  parameter int         STREAM_BYTES = 56,
  parameter int         SYNC_STAGES  = 2
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  output logic [7:0]  reg_addr,
  output logic [15:0] reg_wdata,
  output logic        reg_we,
  input  logic [15:0] reg_rdata,
  output logic        reg_rd_strobe
);
  logic scl_s, sda_s, scl_rise, scl_fall, start_ev, stop_ev;

  i2c_line_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .scl_i(scl_i), .sda_i(sda_i),
    .scl_s(scl_s), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev)
  );

  i2c_word_fsm #(
    .DEV_ADDR(DEV_ADDR), .STREAM_ADDR(STREAM_ADDR), .STREAM_BYTES(STREAM_BYTES)
  ) u_fsm (
    .clk(clk), .rst(rst), .sda_s(sda_s), .scl_rise(scl_rise), .scl_fall(scl_fall),
    .start_ev(start_ev), .stop_ev(stop_ev), .reg_rdata(reg_rdata),
    .sda_oe(sda_oe), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_we(reg_we), .reg_rd_strobe(reg_rd_strobe)
  );
endmodule

// File: rtl/i2c_word_slave_chk.sv
module i2c_word_slave_chk #(
  parameter logic [7:0] STREAM_ADDR = 8'h04
) (
  input logic       clk,
  input logic       rst,
  input logic       scl_s,
  input logic       scl_fall,
  input logic       start_ev,
  input logic       stop_ev,
  input logic       sda_oe,
  input logic       reg_we,
  input logic       reg_rd_strobe,
  input logic [7:0] reg_addr
);
  // R12
  oe_rise_on_low_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sda_oe) |-> $past(scl_fall));
  // R12
  oe_steady_high_chk: assert property (@(posedge clk) disable iff (rst)
    (scl_s && !start_ev && !stop_ev) |=> $stable(sda_oe));
  // R3
  we_single_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reg_we |=> !reg_we);
  // R9
  pop_stream_only_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rd_strobe |-> (reg_addr == STREAM_ADDR));
  // R11
  stop_release_chk: assert property (@(posedge clk) disable iff (rst)
    stop_ev |=> !sda_oe);
endmodule

bind i2c_word_slave i2c_word_slave_chk #(.STREAM_ADDR(STREAM_ADDR)) u_chk (
  .clk(clk), .rst(rst), .scl_s(scl_s), .scl_fall(scl_fall),
  .start_ev(start_ev), .stop_ev(stop_ev), .sda_oe(sda_oe),
  .reg_we(reg_we), .reg_rd_strobe(reg_rd_strobe), .reg_addr(reg_addr)
);

// File: tb/sim_i2c_word_slave.sv
module sim_i2c_word_slave;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, reg_we, reg_rd_strobe;
  logic [7:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  wire sda_line = sda_m & ~sda_oe;

  i2c_word_slave u0 (
    .clk(clk), .rst(rst), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_we(reg_we),
    .reg_rdata(reg_rdata), .reg_rd_strobe(reg_rd_strobe)
  );

  // behavioural register file and stream source
  logic [15:0] mem [256];
  int sidx = 0, we_cnt = 0, pop_cnt = 0, oe_viol = 0;
  logic [7:0]  last_wa = '0;
  logic [15:0] last_wd = '0;
  logic oe_prev = 1'b0, scl_prev = 1'b1;
  int checks = 0, failures = 0;

  always_comb reg_rdata = (reg_addr == 8'h04) ? (16'hA000 + 16'(sidx)) : mem[reg_addr];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 256; i++) mem[i] <= {i[7:0], ~i[7:0]};
    end else begin
      if (reg_we) begin
        mem[reg_addr] <= reg_wdata;
        last_wa <= reg_addr;
        last_wd <= reg_wdata;
        we_cnt  <= we_cnt + 1;
      end
      if (reg_rd_strobe) begin
        sidx    <= sidx + 1;
        pop_cnt <= pop_cnt + 1;
      end
    end
  end

  // per-clock model: no new SDA drive while SCL held high (R12)
  always @(negedge clk) begin
    if (!rst && sda_oe && !oe_prev && scl_m && scl_prev) oe_viol = oe_viol + 1;
    oe_prev  = sda_oe;
    scl_prev = scl_m;
  end

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq();
    repeat (8) @(negedge clk);
  endtask

  task automatic m_start();
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); sda_m = 1'b0; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic m_stop();
    sda_m = 1'b0; wq(); scl_m = 1'b1; wq(); sda_m = 1'b1; wq();
  endtask

  task automatic m_wbyte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
    end
    sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); ack = ~sda_line; wq(); scl_m = 1'b0; wq();
  endtask

  task automatic m_rbyte(input logic give_ack, output logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      sda_m = 1'b1; wq(); scl_m = 1'b1; wq(); b[i] = sda_line; wq(); scl_m = 1'b0; wq();
    end
    sda_m = ~give_ack; wq(); scl_m = 1'b1; wq(); wq(); scl_m = 1'b0; wq();
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
    summary();
    $finish;
  end

  initial begin
    logic a0, a1, a2, a3, a4, a5;
    logic [7:0] b0, b1, b2, b3;
    int w0, p0;
    repeat (4) @(negedge clk);
    // R1 reset values
    chk(sda_oe == 1'b0 && reg_we == 1'b0 && reg_rd_strobe == 1'b0, "R1 outputs",
        {sda_oe, reg_we, reg_rd_strobe}, 0);
    chk(reg_addr == 8'h00, "R1 reg_addr", reg_addr, 0);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // R3 word write 0xBEEF to 0x41, R4 two extra bytes
    m_start();
    m_wbyte(8'h68, a0); m_wbyte(8'h41, a1); m_wbyte(8'hBE, a2); m_wbyte(8'hEF, a3);
    w0 = we_cnt;
    m_wbyte(8'h12, a4); m_wbyte(8'h34, a5);
    m_stop();
    chk({a0, a1, a2, a3} == 4'hF, "R2 R3 acks", {a0, a1, a2, a3}, 4'hF);
    chk(w0 == 1 && last_wa == 8'h41 && last_wd == 16'hBEEF, "R3 write",
        {last_wa, last_wd}, 24'h41BEEF);
    chk(a4 && a5, "R4 extra acks", {a4, a5}, 2'b11);
    chk(we_cnt == 1, "R4 no extra write", we_cnt, 1);

    // R5 partial write to 0x42
    m_start();
    m_wbyte(8'h68, a0); m_wbyte(8'h42, a1); m_wbyte(8'h99, a2);
    m_stop();
    chk(we_cnt == 1, "R5 no write", we_cnt, 1);

    // R6 word read of 0x41
    m_start(); m_wbyte(8'h68, a0); m_wbyte(8'h41, a1);
    m_start(); m_wbyte(8'h69, a2);
    m_rbyte(1'b1, b0); m_rbyte(1'b0, b1); m_stop();
    chk({b0, b1} == 16'hBEEF, "R6 word read", {b0, b1}, 16'hBEEF);

    // R5 at ports: 0x42 still holds its initial word
    m_start(); m_wbyte(8'h68, a0); m_wbyte(8'h42, a1);
    m_start(); m_wbyte(8'h69, a2);
    m_rbyte(1'b1, b0); m_rbyte(1'b0, b1); m_stop();
    chk({b0, b1} == 16'h42BD, "R5 untouched", {b0, b1}, 16'h42BD);

    // R7 repeat-address read
    m_start(); m_wbyte(8'h69, a0);
    m_rbyte(1'b1, b0); m_rbyte(1'b0, b1); m_stop();
    chk(a0 && {b0, b1} == 16'h42BD, "R7 repeat read", {b0, b1}, 16'h42BD);

    // R8 multi-byte read on ordinary register
    m_start(); m_wbyte(8'h68, a0); m_wbyte(8'h41, a1);
    m_start(); m_wbyte(8'h69, a2);
    m_rbyte(1'b1, b0); m_rbyte(1'b1, b1); m_rbyte(1'b1, b2); m_rbyte(1'b0, b3); m_stop();
    chk({b0, b1, b2, b3} == 32'hBEEFBEEF, "R8 repeat word", {b0, b1, b2, b3}, 32'hBEEFBEEF);
    chk(pop_cnt == 0, "R9 no pop off stream", pop_cnt, 0);

    // R2 foreign address ignored
    m_start();
    m_wbyte(8'h6A, a0); m_wbyte(8'h41, a1); m_wbyte(8'h00, a2); m_wbyte(8'h00, a3);
    m_stop();
    chk(!a0 && !a1 && !a2 && !a3, "R2 nack foreign", {a0, a1, a2, a3}, 0);
    chk(we_cnt == 1, "R2 no write", we_cnt, 1);

    // R9 R10 stream of 60 bytes
    m_start(); m_wbyte(8'h68, a0); m_wbyte(8'h04, a1);
    m_start(); m_wbyte(8'h69, a2);
    p0 = 0;
    for (int n = 0; n < 60; n++) begin
      logic [7:0] eb;
      m_rbyte(n != 59, b0);
      if (n >= 56)       eb = 8'h00;
      else if (n % 2 == 0) eb = 8'hA0;
      else               eb = 8'(n / 2);
      if (b0 != eb) p0++;
      if (n == 1) chk(pop_cnt == 1, "R9 pop after first word", pop_cnt, 1);
    end
    chk(p0 == 0, "R9 R10 stream bytes", p0, 0);
    chk(pop_cnt == 28, "R10 pop count", pop_cnt, 28);

    // R11 after host nack, slave keeps SDA released
    m_rbyte(1'b0, b0);
    chk(b0 == 8'hFF, "R11 released", b0, 8'hFF);
    m_stop();
    chk(sda_oe == 1'b0, "R11 after stop", sda_oe, 0);
    chk(oe_viol == 0, "R12 drive timing", oe_viol, 0);

    summary();
    $finish;
  end
endmodule